// File: doc/BRIEF.md
# Dual-space DSP address generator

This block computes effective addresses and post-modified pointers for a 64 KB byte-addressed data space that is split into a lower X region and an upper Y region. The split point is fixed when the block is instantiated. Each region has its own generator. Ordinary accesses use only the X generator. A dual-operand multiply-accumulate access asserts `dual_i`, so that one operand address comes from each generator in the same cycle.

Both generators can bound the pointer to a circular buffer set by an inclusive start address and an inclusive end address. When circular mode and bit-reversed mode are both off, the update is a plain add of a signed byte step. Only the X generator has bit-reversed mode, and it takes effect only on destination accesses. In that mode a power-of-two modifier is added with its carry running from the top bit down to bit 0, which produces the reordering used by radix-2 FFTs.

All outputs are registered. Inputs sampled at a rising clock edge appear at the outputs after that edge.

Top module: `dual_agu`

## Requirements
- R1: While `rst_ni` is low, every output is 0.
- R2: When circular mode and bit-reversed mode are both off, the updated pointer is the pointer plus the signed step, modulo 2^16. The effective address is the incoming pointer. Both outputs appear one clock edge after the inputs are sampled.
- R3: A word access (`*_byte_i` = 0) forces bit 0 of both the effective address and the updated pointer to 0. A byte access (`*_byte_i` = 1) leaves bit 0 as computed.
- R4: In circular mode with a non-negative step, a sum greater than the end address has L = end - start + 1 subtracted from it.
- R5: In circular mode with a negative step, a sum below the start address has L added to it.
- R6: When `x_brev_en_i` = 1 and `x_dst_i` = 1, the X updated pointer is the pointer plus the modifier, with the carry running from bit 15 toward bit 0. This takes priority over circular mode. The modifier must have exactly one bit set.
- R7: When `x_dst_i` = 0, `x_brev_en_i` has no effect, and the X update is linear or circular as R2, R4 and R5 describe.
- R8: The Y outputs (`y_ea_o`, `y_next_o`) load new values only when `dual_i` = 1. Otherwise they hold.
- R9: When `dual_i` = 1, `x_oob_o` = 1 if the X effective address is at or above `Y_BASE`, and `y_oob_o` = 1 if the Y effective address is below `Y_BASE`. When `dual_i` = 0, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_i | input | 1 | Dual-operand access: both generators active |
| x_ptr_i | input | 16 | X pointer (byte address) |
| x_step_i | input | 16 | X signed byte step |
| x_mod_en_i | input | 1 | X circular mode enable |
| x_mod_start_i | input | 16 | X buffer start, inclusive |
| x_mod_end_i | input | 16 | X buffer end, inclusive |
| x_byte_i | input | 1 | X access size: 1 byte, 0 word |
| x_dst_i | input | 1 | X access is a destination |
| x_brev_en_i | input | 1 | X bit-reversed mode enable |
| x_brev_mod_i | input | 16 | X bit-reverse modifier (power of two) |
| y_ptr_i | input | 16 | Y pointer (byte address) |
| y_step_i | input | 16 | Y signed byte step |
| y_mod_en_i | input | 1 | Y circular mode enable |
| y_mod_start_i | input | 16 | Y buffer start, inclusive |
| y_mod_end_i | input | 16 | Y buffer end, inclusive |
| y_byte_i | input | 1 | Y access size: 1 byte, 0 word |
| x_ea_o | output | 16 | X effective address |
| x_next_o | output | 16 | X updated pointer |
| x_oob_o | output | 1 | X address falls in Y region during a dual access |
| y_ea_o | output | 16 | Y effective address |
| y_next_o | output | 16 | Y updated pointer |
| y_oob_o | output | 1 | Y address falls in X region during a dual access |

## Verification
The assertions check on every cycle that:
- word accesses keep bit 0 clear;
- a pointer inside its circular buffer stays inside it for small steps;
- the Y outputs hold whenever no dual access occurred;
- the region flags only rise after a dual access;
- every bit-reverse modifier that is used has a single bit set.

Only the bench scenarios can show the exact values:
- the wrap targets for upward and downward steps;
- the reverse-carry sequence 0, 8, 4, C, 2;
- bit-reversed mode overriding circular mode, and being ignored on source accesses;
- the exact flag decisions at the `Y_BASE` boundary.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned DATA_BYTES = 64 * 1024;
  localparam int unsigned ADDR_W     = $clog2(DATA_BYTES);
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/agu_lin_mod.sv
module agu_lin_mod
  import agu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic          mod_en_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          byte_i,
  output logic [AW-1:0] next_o
);
  localparam int unsigned SW = AW + 2;
  localparam logic signed [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

  logic signed [SW-1:0] sum, len, lo, hi, res;
  logic                 neg;
  logic [1:0]           unused_hi;

  always_comb begin
    neg = step_i[AW-1];
    lo  = $signed({2'b00, start_i});
    hi  = $signed({2'b00, end_i});
    sum = $signed({2'b00, ptr_i}) + $signed({{2{step_i[AW-1]}}, step_i});
    len = hi - lo + ONE;
    res = sum;
    if (mod_en_i && !neg && (sum > hi))     res = sum - len;
    else if (mod_en_i && neg && (sum < lo)) res = sum + len;
  end

  assign unused_hi = res[SW-1:AW];
  assign next_o    = {res[AW-1:1], res[0] & byte_i};
endmodule

// File: rtl/agu_brev.sv
module agu_brev
  import agu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic          byte_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] rev_ptr, rev_mod, rev_sum, fwd;

  // reverse, add, reverse back: carry runs MSB -> LSB
  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign rev_ptr[i] = ptr_i[AW-1-i];
    assign rev_mod[i] = mod_i[AW-1-i];
    assign fwd[i]     = rev_sum[AW-1-i];
  end

  assign rev_sum = rev_ptr + rev_mod;
  assign next_o  = {fwd[AW-1:1], fwd[0] & byte_i};
endmodule

// File: rtl/dual_agu.sv
module dual_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter logic [AW-1:0] Y_BASE = AW'(DATA_BYTES / 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dual_i,
  input  logic [AW-1:0] x_ptr_i,
  input  logic [AW-1:0] x_step_i,
  input  logic          x_mod_en_i,
  input  logic [AW-1:0] x_mod_start_i,
  input  logic [AW-1:0] x_mod_end_i,
  input  logic          x_byte_i,
  input  logic          x_dst_i,
  input  logic          x_brev_en_i,
  input  logic [AW-1:0] x_brev_mod_i,
  input  logic [AW-1:0] y_ptr_i,
  input  logic [AW-1:0] y_step_i,
  input  logic          y_mod_en_i,
  input  logic [AW-1:0] y_mod_start_i,
  input  logic [AW-1:0] y_mod_end_i,
  input  logic          y_byte_i,
  output logic [AW-1:0] x_ea_o,
  output logic [AW-1:0] x_next_o,
  output logic          x_oob_o,
  output logic [AW-1:0] y_ea_o,
  output logic [AW-1:0] y_next_o,
  output logic          y_oob_o
);
  logic [AW-1:0] x_lin_nxt, x_brv_nxt, x_nxt, y_nxt, x_ea, y_ea;
  logic          brev_sel;

  agu_lin_mod #(.AW(AW)) u_x_lin (
    .ptr_i(x_ptr_i), .step_i(x_step_i), .mod_en_i(x_mod_en_i),
    .start_i(x_mod_start_i), .end_i(x_mod_end_i), .byte_i(x_byte_i),
    .next_o(x_lin_nxt)
  );

  agu_brev #(.AW(AW)) u_x_brev (
    .ptr_i(x_ptr_i), .mod_i(x_brev_mod_i), .byte_i(x_byte_i),
    .next_o(x_brv_nxt)
  );

  agu_lin_mod #(.AW(AW)) u_y_lin (
    .ptr_i(y_ptr_i), .step_i(y_step_i), .mod_en_i(y_mod_en_i),
    .start_i(y_mod_start_i), .end_i(y_mod_end_i), .byte_i(y_byte_i),
    .next_o(y_nxt)
  );

  assign brev_sel = x_brev_en_i & x_dst_i;
  assign x_nxt    = brev_sel ? x_brv_nxt : x_lin_nxt;
  assign x_ea     = {x_ptr_i[AW-1:1], x_ptr_i[0] & x_byte_i};
  assign y_ea     = {y_ptr_i[AW-1:1], y_ptr_i[0] & y_byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_ea_o   <= '0;
      x_next_o <= '0;
      x_oob_o  <= 1'b0;
      y_ea_o   <= '0;
      y_next_o <= '0;
      y_oob_o  <= 1'b0;
    end else begin
      x_ea_o   <= x_ea;
      x_next_o <= x_nxt;
      x_oob_o  <= dual_i && (x_ea >= Y_BASE);
      y_oob_o  <= dual_i && (y_ea < Y_BASE);
      if (dual_i) begin
        y_ea_o   <= y_ea;
        y_next_o <= y_nxt;
      end
    end
  end

  AST_WORD_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(x_byte_i) |-> (x_next_o[0] == 1'b0 && x_ea_o[0] == 1'b0)); // R3

  AST_MOD_IN_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_mod_en_i && !brev_sel && x_mod_end_i > x_mod_start_i
     && x_ptr_i >= x_mod_start_i && x_ptr_i <= x_mod_end_i
     && ($signed(x_step_i) <= 2) && ($signed(x_step_i) >= -2))
    |-> (x_lin_nxt >= x_mod_start_i && x_lin_nxt <= x_mod_end_i)); // R4

  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dual_i) |-> ($stable(y_next_o) && $stable(y_ea_o))); // R8

  AST_OOB_DUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_oob_o || y_oob_o) |-> $past(dual_i)); // R9

  AST_BREV_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brev_sel |-> ($countones(x_brev_mod_i) == 1)); // R6
endmodule

// File: tb/sim_dual_agu.sv
module sim_dual_agu;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 16;
  localparam logic [15:0] XS = 16'h1000;
  localparam logic [15:0] XE = 16'h101F;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] ptr;
    logic [15:0] step;
    logic        mod_en;
    logic        byt;
    logic        brev;
    logic        dst;
    logic [15:0] bmod;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{4'd2, 16'h0100, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0102}, // R2
    '{4'd2, 16'h0100, 16'hFFFC, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h00FC}, // R2
    '{4'd3, 16'h0101, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0102}, // R3
    '{4'd3, 16'h0101, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0102}, // R3
    '{4'd4, 16'h101E, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1000}, // R4
    '{4'd4, 16'h1010, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1012}, // R4
    '{4'd5, 16'h1000, 16'hFFFE, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h101E}, // R5
    '{4'd5, 16'h1001, 16'hFFFE, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h101F}, // R5
    '{4'd6, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0008, 16'h0008}, // R6
    '{4'd6, 16'h0008, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0008, 16'h0004}, // R6
    '{4'd6, 16'h000C, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0008, 16'h0002}, // R6
    '{4'd6, 16'h0004, 16'h0002, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0008, 16'h000C}, // R6
    '{4'd6, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h4000}, // R6
    '{4'd7, 16'h0008, 16'h0002, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0008, 16'h000A}, // R7
    '{4'd2, 16'h101E, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1020}, // R2
    '{4'd2, 16'hFFFE, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0002}  // R2
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, dual_i = 1'b0;
  logic [15:0] x_ptr_i = '0, x_step_i = '0, x_mod_start_i = XS, x_mod_end_i = XE;
  logic x_mod_en_i = 1'b0, x_byte_i = 1'b0, x_dst_i = 1'b0, x_brev_en_i = 1'b0;
  logic [15:0] x_brev_mod_i = '0, y_ptr_i = '0, y_step_i = '0;
  logic [15:0] y_mod_start_i = 16'h9000, y_mod_end_i = 16'h900F;
  logic y_mod_en_i = 1'b0, y_byte_i = 1'b0;
  logic [15:0] x_ea_o, x_next_o, y_ea_o, y_next_o;
  logic x_oob_o, y_oob_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_agu u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_clk;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 x_ea", x_ea_o, 16'h0);
    chk("R1 x_next", x_next_o, 16'h0);
    chk("R1 y_next", y_next_o, 16'h0);
    chk("R1 oob", {14'h0, x_oob_o, y_oob_o}, 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      x_ptr_i      = VECS[i].ptr;
      x_step_i     = VECS[i].step;
      x_mod_en_i   = VECS[i].mod_en;
      x_byte_i     = VECS[i].byt;
      x_brev_en_i  = VECS[i].brev;
      x_dst_i      = VECS[i].dst;
      x_brev_mod_i = VECS[i].bmod;
      step_clk();
      chk($sformatf("R%0d vec%0d next", VECS[i].req, i), x_next_o, VECS[i].exp);
      chk($sformatf("R%0d vec%0d ea", VECS[i].req, i), x_ea_o,
          VECS[i].byt ? VECS[i].ptr : {VECS[i].ptr[15:1], 1'b0});
    end
    x_brev_en_i = 1'b0; x_dst_i = 1'b0; x_brev_mod_i = '0; x_mod_en_i = 1'b0;
    x_byte_i = 1'b0; x_ptr_i = 16'h0200; x_step_i = 16'h0002;

    // R8 Y updates in dual mode, holds otherwise
    dual_i = 1'b1; y_ptr_i = 16'h9000; y_step_i = 16'h0002;
    step_clk();
    chk("R8 y_next dual", y_next_o, 16'h9002);
    chk("R8 y_ea dual", y_ea_o, 16'h9000);
    dual_i = 1'b0; y_ptr_i = 16'h9100;
    step_clk();
    chk("R8 y_next hold", y_next_o, 16'h9002);
    chk("R8 y_ea hold", y_ea_o, 16'h9000);

    // R4 / R5 on Y generator
    dual_i = 1'b1; y_mod_en_i = 1'b1; y_ptr_i = 16'h900E; y_step_i = 16'h0002;
    step_clk();
    chk("R4 y wrap up", y_next_o, 16'h9000);
    y_ptr_i = 16'h9000; y_step_i = 16'hFFFE;
    step_clk();
    chk("R5 y wrap down", y_next_o, 16'h900E);
    y_mod_en_i = 1'b0;

    // R9 region flags
    x_ptr_i = 16'h8000; y_ptr_i = 16'h7FFE;
    step_clk();
    chk("R9 x_oob set", {15'h0, x_oob_o}, 16'h1);
    chk("R9 y_oob set", {15'h0, y_oob_o}, 16'h1);
    x_ptr_i = 16'h7FFE; y_ptr_i = 16'h8000;
    step_clk();
    chk("R9 flags clear in range", {14'h0, x_oob_o, y_oob_o}, 16'h0);
    dual_i = 1'b0; x_ptr_i = 16'h8000; y_ptr_i = 16'h7FFE;
    step_clk();
    chk("R9 flags off single", {14'h0, x_oob_o, y_oob_o}, 16'h0);

    // R1 asynchronous reset clears outputs again
    rst_ni = 1'b0;
    #1;
    chk("R1 async x_next", x_next_o, 16'h0);
    chk("R1 async y_next", y_next_o, 16'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule